// File: doc/BRIEF.md
# Compressed Stream Sync Detector

This block watches the stream of 16-bit words recovered from a consumer digital audio link. It raises a flag when a fixed six-word synchronisation signature appears, which marks the payload as a compressed bitstream rather than linear PCM. Some sources set the channel-status audio/non-audio bit wrongly, so the block does not use that bit. It looks only at the data words themselves.

Each accepted word arrives with a valid strobe. A separate strobe marks every frame boundary. Once the signature is seen, the flag stays high for a retriggerable window of frames. Every further signature restarts the window. If the window runs out with no new signature, the flag drops and stays low until the next complete signature.

Top module: `burst_sync_detector`

## Requirements
- R1: After a synchronous reset, `detect` is 0.
- R2: When the valid words 0x0000, 0x0000, 0x0000, 0x0000, 0xF872 and 0x4E1F arrive in that order, `detect` is 1 on the second rising clock edge after the edge that accepts 0x4E1F. It is still 0 after the first of those edges.
- R3: A cycle with `word_vld` low has no effect on the match, whatever is on `word_data`. Valid words separated by idle cycles still form a signature.
- R4: A valid word other than the expected one breaks a partial match. A sequence that breaks before 0x4E1F leaves `detect` at 0.
- R5: Extra leading zeros are absorbed. Any run of five or more zeros followed by 0xF872 and 0x4E1F is detected.
- R6: With `WINDOW_FRAMES` = 4096, `detect` stays 1 through 4095 frame strobes after a detection. It falls to 0 on the edge that accepts the 4096th strobe.
- R7: A new signature while `detect` is 1 restarts the frame window from zero.
- R8: After a timeout, `detect` stays 0 until a complete signature arrives. Further frame strobes do not raise it.
- R9: A 0x0000 that arrives where 0x4E1F is expected counts as the first zero of a new signature.
- R10: If a frame strobe arrives in the same cycle as the internal detection pulse, the restart takes priority and that strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | Marks `word_data` as a received word this cycle |
| word_data | input | 16 | Received audio word |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| detect | output | 1 | Registered flag: compressed-stream signature seen within the window |

## Verification
Two cases are hard to reach from the ports. The first is a frame strobe in the very cycle where the internal match pulse is present. The bench drives that strobe exactly one cycle after the final signature word, then counts the remaining window precisely to show that the strobe was dropped. The second is the overlapping restart cases: extra zeros, and a zero in place of the last word. The bench sends tailored word sequences that only a correct fallback rule turns into a detection.

// File: rtl/burst_sync_pkg.sv
package burst_sync_pkg;
  localparam int WORD_W   = 16;
  localparam int PAT_LEN  = 6;
  localparam int ZERO_RUN = 4;
  localparam int IDX_W    = $clog2(PAT_LEN);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam idx_t LAST_IDX = idx_t'(PAT_LEN - 1);
  localparam idx_t RUN_IDX  = idx_t'(ZERO_RUN);

  // expected word at each position of the signature
  function automatic word_t sig_word(input idx_t pos);
    case (pos)
      idx_t'(4): sig_word = 16'hF872;
      idx_t'(5): sig_word = 16'h4E1F;
      default:   sig_word = '0;
    endcase
  endfunction
endpackage

// File: rtl/sync_pattern_matcher.sv
module sync_pattern_matcher
  import burst_sync_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  word_vld,
  input  word_t word_data,
  output logic  hit
);
  idx_t pos_q, pos_d;
  logic hit_d;
  logic is_zero, is_expected;

  assign is_zero     = (word_data == '0);
  assign is_expected = (word_data == sig_word(pos_q));

  always_comb begin
    pos_d = pos_q;
    hit_d = 1'b0;
    if (word_vld) begin
      if (is_expected) begin
        if (pos_q == LAST_IDX) begin
          pos_d = '0;
          hit_d = 1'b1;
        end else begin
          pos_d = pos_q + idx_t'(1);
        end
      end else if (is_zero) begin
        // keep the longest usable zero run
        pos_d = (pos_q == RUN_IDX) ? RUN_IDX : idx_t'(1);
      end else begin
        pos_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      hit   <= 1'b0;
    end else begin
      pos_q <= pos_d;
      hit   <= hit_d;
    end
  end

  // R2
  hit_source_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(word_vld) && ($past(word_data) == 16'h4E1F));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(word_vld) |-> ($stable(pos_q) && !hit));

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST_IDX);
endmodule

// File: rtl/frame_window_timer.sv
module frame_window_timer #(
  parameter int WINDOW_FRAMES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic frame_stb,
  output logic active
);
  localparam int CW = (WINDOW_FRAMES > 1) ? $clog2(WINDOW_FRAMES) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW_FRAMES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= LIMIT;
      active <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      active <= 1'b1;
    end else if (frame_stb && active) begin
      if (cnt_q == LIMIT) begin
        active <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R8
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(restart));

  // R7
  restart_on_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> active);

  // R6
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(frame_stb) && !$past(restart));
endmodule

// File: rtl/burst_sync_detector.sv
module burst_sync_detector #(
  parameter int WINDOW_FRAMES = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        word_vld,
  input  logic [15:0] word_data,
  input  logic        frame_stb,
  output logic        detect
);
  logic sig_hit;

  sync_pattern_matcher u_match (
    .clk       (clk),
    .rst       (rst),
    .word_vld  (word_vld),
    .word_data (word_data),
    .hit       (sig_hit)
  );

  frame_window_timer #(.WINDOW_FRAMES(WINDOW_FRAMES)) u_window (
    .clk       (clk),
    .rst       (rst),
    .restart   (sig_hit),
    .frame_stb (frame_stb),
    .active    (detect)
  );

  // R10
  collide_chk: assert property (@(posedge clk) disable iff (rst)
    (sig_hit && frame_stb) |=> detect);
endmodule

// File: tb/test_burst_sync_detector.sv
module test_burst_sync_detector;
  logic        clk = 1'b0;
  logic        rst;
  logic        word_vld;
  logic [15:0] word_data;
  logic        frame_stb;
  logic        detect;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  burst_sync_detector #(.WINDOW_FRAMES(4096)) i_burst_sync_detector (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_data(word_data),
    .frame_stb(frame_stb), .detect(detect)
  );

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: detect actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w);
    word_vld = 1'b1; word_data = w;
    @(negedge clk);
    word_vld = 1'b0; word_data = 16'hABCD;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      word_data = 16'h4E1F;
      @(negedge clk);
    end
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frame_stb = 1'b1;
      @(negedge clk);
    end
    frame_stb = 1'b0;
  endtask

  task automatic send_sig();
    for (int i = 0; i < 4; i++) send_word(16'h0000);
    send_word(16'hF872);
    send_word(16'h4E1F);
  endtask

  task automatic expire();
    frames(4096);
    check("R6 clear", detect, 1'b0);
  endtask

  task automatic t_reset();
    check("R1", detect, 1'b0);
  endtask

  task automatic t_basic_window();
    send_sig();
    check("R2 early", detect, 1'b0);
    @(negedge clk);
    check("R2", detect, 1'b1);
    frames(4095);
    check("R6 hold", detect, 1'b1);
    frames(1);
    check("R6 drop", detect, 1'b0);
    frames(20);
    idle(3);
    check("R8", detect, 1'b0);
  endtask

  task automatic t_gaps();
    send_word(16'h0000); idle(2);
    send_word(16'h0000); send_word(16'h0000); idle(1);
    send_word(16'h0000); idle(4);
    send_word(16'hF872); idle(2);
    send_word(16'h4E1F);
    @(negedge clk);
    check("R3", detect, 1'b1);
    expire();
  endtask

  task automatic t_broken();
    for (int i = 0; i < 4; i++) send_word(16'h0000);
    send_word(16'hF872);
    send_word(16'h1234);
    send_word(16'h4E1F);
    idle(2);
    check("R4 bad tail", detect, 1'b0);
    send_word(16'h0000); send_word(16'h0000); send_word(16'h0007);
    send_word(16'h0000); send_word(16'h0000);
    send_word(16'hF872); send_word(16'h4E1F);
    idle(2);
    check("R4 bad zero", detect, 1'b0);
  endtask

  task automatic t_overlap();
    for (int i = 0; i < 7; i++) send_word(16'h0000);
    send_word(16'hF872);
    send_word(16'h4E1F);
    @(negedge clk);
    check("R5", detect, 1'b1);
    expire();
  endtask

  task automatic t_zero_in_tail();
    for (int i = 0; i < 4; i++) send_word(16'h0000);
    send_word(16'hF872);
    send_word(16'h0000);
    send_word(16'h0000); send_word(16'h0000); send_word(16'h0000);
    send_word(16'hF872);
    send_word(16'h4E1F);
    @(negedge clk);
    check("R9", detect, 1'b1);
    expire();
  endtask

  task automatic t_retrigger();
    send_sig(); @(negedge clk);
    frames(3000);
    check("R7 first", detect, 1'b1);
    send_sig(); @(negedge clk);
    frames(3000);
    check("R7 extended", detect, 1'b1);
    frames(1095);
    check("R7 hold", detect, 1'b1);
    frames(1);
    check("R7 drop", detect, 1'b0);
  endtask

  task automatic t_collision();
    send_sig();
    frames(1);
    check("R10 set", detect, 1'b1);
    frames(4095);
    check("R10 hold", detect, 1'b1);
    frames(1);
    check("R10 drop", detect, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog (all): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; word_vld = 1'b0; word_data = '0; frame_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_window();
    t_gaps();
    t_broken();
    t_overlap();
    t_zero_in_tail();
    t_retrigger();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule